// File: doc/BRIEF.md
# Serial Byte-Memory Bus Slave Engine

This block is the bus-facing controller of a small serial byte memory that answers as a slave on an I2C bus. A fast system clock oversamples the SCL and SDA lines. The engine recognises START and STOP conditions and takes in the 8-bit device-select byte. It compares the strap-selected bits of that byte with its strap pins and acknowledges by pulling the open-drain data line low. It then carries out writes of one byte or a page, and reads at the current address, at a random address or sequentially.

Behind the engine sits a storage array or page buffer with a byte-wide port. A write strobe carries address and data together. A read strobe must be answered on `mem_rdata` one cycle later. A busy input from the write-cycle timer makes the engine deaf to its own address. A write-protect input lets the addresses through but refuses data. A one-cycle commit pulse tells the write buffer to start programming once a write transaction with data has ended in STOP.

The array size sets how many device-select bits are array address bits and how many are compared with straps. The array address is `ADDR_W` bits wide, from 8 to 11. The lowest `ADDR_W-8` select bits are address bits, starting at a8 in byte bit 1. The remaining select bits, up to byte bit 3, are compared with `strap_sel`, where byte bit 1+i is compared with `strap_sel[i]`. The default is a 512-byte array with 16-byte pages.

Top module: `i2cmem_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts device-byte reception from any state. A rising SDA while SCL is high (STOP) returns to idle. Either one discards a partly received byte.
- R2: The device byte arrives MSB first. Bits 7..4 must be 1010, bit 0 is the direction (1 = read) and the strap-compared select bits must equal `strap_sel`. A matching byte is acknowledged by a low level during the ninth SCL pulse. A byte that does not match gets no acknowledge, and the engine stays silent until the next START.
- R3: While `busy_i` is high, a device byte is never acknowledged, even when it matches.
- R4: In a write, the second byte loads the low 8 address bits. Every later data byte is acknowledged and produces one `mem_wr_en` cycle carrying `mem_addr` and `mem_wdata`. After each data byte only the low `PAGE_W` address bits advance, wrapping inside the page.
- R5: With `wp_i` high, the device and word bytes are acknowledged, the first data byte is not, and no `mem_wr_en` is produced.
- R6: A STOP that ends a write in which at least one data byte was accepted gives exactly one `commit_o` cycle. A STOP without accepted data gives none.
- R7: A write carrying only the word address, followed by a repeated START and a matching read byte, returns the byte stored at that address.
- R8: A read with no address phase returns the byte after the last one read or written.
- R9: During a read, each low acknowledge from the master brings the next byte. Read addresses advance over the whole array and wrap from the top address to 0.
- R10: After the master leaves a read byte unacknowledged, the engine keeps SDA released until the next START or STOP.
- R11: In a write, the array address bits in the device byte supply the upper address bits (for a 512-byte array, byte bit 1 is a8). These bits are never compared with straps.
- R12: `sda_drive_low` is low after reset and changes only while the synchronised SCL is low. Every rise follows a detected SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired value) |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_sel | input | 3 | Strap levels for the compared select bits |
| wp_i | input | 1 | Write protect, 1 refuses data bytes |
| busy_i | input | 1 | Internal write cycle in progress |
| mem_addr | output | ADDR_W (9) | Array address for read or write strobe |
| mem_wr_en | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Data byte for the write strobe |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd_en` |
| commit_o | output | 1 | One-cycle pulse to start programming |

## Verification
The assertions rely on the master keeping SCL low for several system clocks around every data change. They also rely on the master never making a START or STOP while the engine is pulling SDA low. They further assume that `wp_i` and `busy_i` change only between transactions. The bench's bit-level master tasks hold SCL low for eight clocks per bit and change SDA only in the middle of that low phase. Protect and busy are changed only while the bus is idle. The storage model answers every read strobe in the following cycle.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_RNEXT,
    ST_HOLD
  } eng_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Device byte matches when the type nibble is right and every select
  // bit that is not an array address bit equals its strap.
  function automatic logic dev_match(input logic [7:0] b,
                                     input logic [2:0] strap,
                                     input int n_upper);
    logic ok;
    ok = (b[7:4] == DEV_TYPE);
    for (int i = 0; i < 3; i++) begin
      if (i >= n_upper && b[i+1] != strap[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  // Upper address bits from the device byte joined with the word byte.
  function automatic logic [15:0] join_addr(input logic [2:0] upper,
                                            input logic [7:0] word);
    return {5'b0, upper, word};
  endfunction

  // Advance only the low pw bits, keeping the page number.
  function automatic logic [15:0] page_inc(input logic [15:0] a,
                                           input int pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

endpackage

// File: rtl/i2cmem_line_sync.sv
module i2cmem_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe;
  logic [MSB:0] sda_pipe;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
          sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[MSB];
      sda_q <= sda_pipe[MSB];
    end
  end

  assign scl_s    = scl_pipe[MSB];
  assign sda_s    = sda_pipe[MSB];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cmem_dev_decode.sv
module i2cmem_dev_decode #(
  parameter int ADDR_W = 9
) (
  input  logic [7:0] dev_byte,
  input  logic [2:0] strap_sel,
  output logic       hit,
  output logic       is_read,
  output logic [2:0] upper
);
  import i2cmem_pkg::*;
  localparam int N_UPPER = ADDR_W - 8;

  assign hit     = dev_match(dev_byte, strap_sel, N_UPPER);
  assign is_read = dev_byte[0];
  assign upper   = dev_byte[3:1];

endmodule

// File: rtl/i2cmem_ptr.sv
module i2cmem_ptr #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [2:0]        ld_upper,
  input  logic [7:0]        ld_word,
  input  logic              inc_full,
  input  logic              inc_page,
  output logic [ADDR_W-1:0] ptr
);
  import i2cmem_pkg::*;
  localparam int PAD = 16 - ADDR_W;

  logic [15:0] joined, paged;

  assign joined = join_addr(ld_upper, ld_word);
  assign paged  = page_inc({{PAD{1'b0}}, ptr}, PAGE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (ld)       ptr <= joined[ADDR_W-1:0];
    else if (inc_full) ptr <= ptr + 1'b1;
    else if (inc_page) ptr <= paged[ADDR_W-1:0];
  end

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low,
  input  logic [2:0]        strap_sel,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wdata,
  output logic              mem_rd_en,
  input  logic [7:0]        mem_rdata,
  output logic              commit_o
);
  import i2cmem_pkg::*;

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;
  localparam logic [3:0] LAST_TX_BIT   = 4'd7;

  eng_state_t state;
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0] shreg, txbyte, rdbuf;
  logic [3:0] bitcnt;
  logic ack_drive, is_read_q, wrote_any, rd_cap;
  logic [2:0] stash;
  logic dec_hit, dec_read;
  logic [2:0] dec_upper;
  logic [ADDR_W-1:0] ptr;

  // named events for the checker
  logic byte_done, ev_addr_ack, ptr_ld, ptr_inc_full, ptr_inc_page;

  i2cmem_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cmem_dev_decode #(.ADDR_W(ADDR_W)) u_dec (
    .dev_byte(shreg), .strap_sel(strap_sel),
    .hit(dec_hit), .is_read(dec_read), .upper(dec_upper)
  );

  assign byte_done    = scl_fall && (bitcnt == BITS_PER_BYTE);
  assign ev_addr_ack  = (state == ST_DEV) && byte_done && dec_hit && !busy_i;
  assign ptr_ld       = (state == ST_WORD) && byte_done;
  assign ptr_inc_full = (ev_addr_ack && dec_read) ||
                        ((state == ST_RACK) && scl_rise && !sda_s);
  assign ptr_inc_page = (state == ST_WDATA) && byte_done && !wp_i;

  i2cmem_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld(ptr_ld), .ld_upper(stash), .ld_word(shreg),
    .inc_full(ptr_inc_full), .inc_page(ptr_inc_page),
    .ptr(ptr)
  );

  assign sda_drive_low = (state == ST_RDATA) ? ~txbyte[7] : ack_drive;

  // storage port strobes and read capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wr_en <= 1'b0;
      mem_wdata <= '0;
      mem_rd_en <= 1'b0;
      rd_cap    <= 1'b0;
      rdbuf     <= '0;
    end else begin
      mem_wr_en <= ptr_inc_page;
      mem_rd_en <= ptr_inc_full;
      rd_cap    <= mem_rd_en;
      if (ptr_inc_full || ptr_inc_page) mem_addr <= ptr;
      if (ptr_inc_page) mem_wdata <= shreg;
      if (rd_cap) rdbuf <= mem_rdata;
    end
  end

  // protocol sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      txbyte    <= '0;
      bitcnt    <= '0;
      ack_drive <= 1'b0;
      is_read_q <= 1'b0;
      wrote_any <= 1'b0;
      stash     <= '0;
      commit_o  <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (start_ev) begin
        state     <= ST_DEV;
        bitcnt    <= '0;
        ack_drive <= 1'b0;
        wrote_any <= 1'b0;
      end else if (stop_ev) begin
        state     <= ST_IDLE;
        ack_drive <= 1'b0;
        commit_o  <= wrote_any;
        wrote_any <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_WORD, ST_WDATA: begin
            if (scl_rise && bitcnt < BITS_PER_BYTE) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (byte_done) begin
              if (state == ST_DEV) begin
                if (ev_addr_ack) begin
                  ack_drive <= 1'b1;
                  is_read_q <= dec_read;
                  state     <= ST_DEV_ACK;
                  if (!dec_read) stash <= dec_upper;
                end else begin
                  state <= ST_HOLD;
                end
              end else if (state == ST_WORD) begin
                ack_drive <= 1'b1;
                state     <= ST_WORD_ACK;
              end else if (wp_i) begin
                state <= ST_HOLD;
              end else begin
                ack_drive <= 1'b1;
                wrote_any <= 1'b1;
                state     <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              ack_drive <= 1'b0;
              bitcnt    <= '0;
              if (state == ST_DEV_ACK && is_read_q) begin
                txbyte <= rdbuf;
                state  <= ST_RDATA;
              end else if (state == ST_DEV_ACK) begin
                state <= ST_WORD;
              end else begin
                state <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == LAST_TX_BIT) begin
                bitcnt <= '0;
                state  <= ST_RACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                txbyte <= {txbyte[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) state <= sda_s ? ST_HOLD : ST_RNEXT;
          end
          ST_RNEXT: begin
            if (scl_fall) begin
              txbyte <= rdbuf;
              bitcnt <= '0;
              state  <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cmem_slave_chk.sv
module i2cmem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_fall,
  input logic stop_ev,
  input logic sda_drive_low,
  input logic busy_i,
  input logic wp_i,
  input logic ev_addr_ack,
  input logic mem_wr_en,
  input logic mem_rd_en,
  input logic commit_o
);

  // R12: data line only moves while the clock is low
  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low != $past(sda_drive_low)) |-> !scl_s);

  // R12, R2: pulling low always follows a detected clock fall
  p_drive_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> $past(scl_fall));

  p_busy_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_ack |-> !busy_i);

  p_wp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !$past(wp_i));

  p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_ev));

  p_commit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  p_port_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_en));

endmodule

bind i2cmem_slave i2cmem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .stop_ev(stop_ev), .sda_drive_low(sda_drive_low), .busy_i(busy_i),
  .wp_i(wp_i), .ev_addr_ack(ev_addr_ack), .mem_wr_en(mem_wr_en),
  .mem_rd_en(mem_rd_en), .commit_o(commit_o)
);

// File: tb/i2cmem_slave_bench.sv
module i2cmem_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 9;
  localparam int HQ = 4;
  localparam int HI = 8;
  localparam int N_VEC = 8;
  // {device byte, busy, expected ack}
  localparam logic [9:0] VEC [N_VEC] = '{
    {8'hAC, 1'b0, 1'b1}, {8'hAE, 1'b0, 1'b1}, {8'hA8, 1'b0, 1'b0},
    {8'hA4, 1'b0, 1'b0}, {8'hBC, 1'b0, 1'b0}, {8'hAC, 1'b1, 1'b0},
    {8'h2C, 1'b0, 1'b0}, {8'hAE, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wp_i = 1'b0, busy_i = 1'b0;
  logic [2:0] strap_sel = 3'b110;
  logic sda_drive_low, mem_wr_en, mem_rd_en, commit_o;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;
  logic bd_we = 1'b0;
  logic [ADDR_W-1:0] bd_addr = '0;
  logic [7:0] bd_data = '0;
  logic [7:0] mem_model [512];
  int nerr = 0, nchk = 0, commit_cnt = 0, bad_edge = 0;
  logic drv_prev = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_drive_low;

  i2cmem_slave u_i2cmem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .strap_sel(strap_sel), .wp_i(wp_i),
    .busy_i(busy_i), .mem_addr(mem_addr), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .commit_o(commit_o)
  );

  always_ff @(posedge clk) begin
    if (bd_we) mem_model[bd_addr] <= bd_data;
    else if (mem_wr_en) mem_model[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem_model[mem_addr];
    if (rst_n && commit_o) commit_cnt <= commit_cnt + 1;
    drv_prev <= sda_drive_low;
    if (rst_n && (sda_drive_low != drv_prev) && scl_m) bad_edge <= bad_edge + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bd_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bd_addr = a; bd_data = d; bd_we = 1'b1;
    tick(1);
    bd_we = 1'b0;
  endtask

  task automatic bus_start();
    tick(HQ); sda_m = 1'b1; tick(HQ); scl_m = 1'b1;
    tick(HI); sda_m = 1'b0; tick(HI); scl_m = 1'b0; tick(HQ);
  endtask

  task automatic bus_stop();
    tick(HQ); sda_m = 1'b0; tick(HQ); scl_m = 1'b1;
    tick(HI); sda_m = 1'b1; tick(HI);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(HQ); sda_m = b[i]; tick(HQ); scl_m = 1'b1; tick(HI); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    tick(HQ); sda_m = 1'b1; tick(HQ); scl_m = 1'b1;
    tick(HI/2); acked = ~sda_line; tick(HI/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(2*HQ); scl_m = 1'b1; tick(HI/2); b = {b[6:0], sda_line};
      tick(HI/2); scl_m = 1'b0;
    end
    tick(HQ); sda_m = ~mack; tick(HQ); scl_m = 1'b1; tick(HI); scl_m = 1'b0;
    tick(HQ); sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] d;
    int c0;
    tick(3);
    chk("R12 reset drive", sda_drive_low, 0);
    chk("R6 reset commit", commit_o, 0);
    chk("R4 reset strobes", {mem_wr_en, mem_rd_en}, 0);
    rst_n = 1'b1;
    tick(4);
    bd_write(9'h124, 8'h9A);
    bd_write(9'h1FE, 8'hC1);
    bd_write(9'h1FF, 8'hC2);
    bd_write(9'h000, 8'hC3);
    bd_write(9'h040, 8'hEE);

    // address match and busy polling table (R2, R3)
    for (int v = 0; v < N_VEC; v++) begin
      busy_i = VEC[v][1];
      bus_start();
      send_byte(VEC[v][9:2], a0);
      bus_stop();
      chk(VEC[v][1] ? "R3 busy ack" : "R2 match ack", a0, VEC[v][0]);
    end
    busy_i = 1'b0;
    tick(4);
    chk("R6 no commit without data", commit_cnt, 0);

    // byte write to 0x123, a8 from device byte bit 1 (R4, R11, R6)
    bus_start();
    send_byte(8'hAE, a0); send_byte(8'h23, a1); send_byte(8'h55, a2);
    bus_stop(); tick(4);
    chk("R4 byte write acks", {a0, a1, a2}, 3'b111);
    chk("R11 upper bit write", mem_model[9'h123], 8'h55);
    chk("R6 commit after write", commit_cnt, 1);

    // page write wrapping inside the page (R4)
    bus_start();
    send_byte(8'hAC, a0); send_byte(8'h3E, a0);
    send_byte(8'h11, a0); send_byte(8'h22, a1); send_byte(8'h33, a2);
    bus_stop(); tick(4);
    chk("R4 page byte 0", mem_model[9'h03E], 8'h11);
    chk("R4 page byte 1", mem_model[9'h03F], 8'h22);
    chk("R4 page wrap", mem_model[9'h030], 8'h33);
    chk("R4 no spill to next page", mem_model[9'h040], 8'hEE);

    // random read (R7), no commit for address-only write (R6)
    bus_start();
    send_byte(8'hAE, a0); send_byte(8'h23, a1);
    bus_start();
    send_byte(8'hAF, a2);
    recv_byte(1'b0, d);
    bus_stop(); tick(4);
    chk("R7 random read acks", {a0, a1, a2}, 3'b111);
    chk("R7 random read data", d, 8'h55);
    chk("R6 no commit on dummy write", commit_cnt, 2);

    // current-address read (R8)
    bus_start();
    send_byte(8'hAD, a0);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R8 current read data", d, 8'h9A);

    // sequential read wrapping to 0 (R9), silence after nack (R10)
    bus_start();
    send_byte(8'hAE, a0); send_byte(8'hFE, a0);
    bus_start();
    send_byte(8'hAD, a0);
    recv_byte(1'b1, d); chk("R9 seq byte 0", d, 8'hC1);
    recv_byte(1'b1, d); chk("R9 seq byte 1", d, 8'hC2);
    recv_byte(1'b0, d); chk("R9 seq wrap to 0", d, 8'hC3);
    recv_byte(1'b0, d); chk("R10 released after nack", d, 8'hFF);
    bus_stop();

    // write protect (R5)
    wp_i = 1'b1;
    tick(2);
    c0 = commit_cnt;
    bus_start();
    send_byte(8'hAC, a0); send_byte(8'h40, a1); send_byte(8'h77, a2);
    bus_stop(); tick(4);
    wp_i = 1'b0;
    chk("R5 protect acks", {a0, a1, a2}, 3'b110);
    chk("R5 protect keeps data", mem_model[9'h040], 8'hEE);
    chk("R5 protect no commit", commit_cnt, c0);

    // abort a partial byte with STOP and with START (R1)
    bus_start();
    send_bits(8'hA0, 3);
    bus_stop(); tick(4);
    chk("R1 idle after stop", sda_drive_low, 0);
    bus_start();
    send_bits(8'hF0, 5);
    bus_start();
    send_byte(8'hAC, a0); send_byte(8'h05, a1); send_byte(8'h66, a2);
    bus_stop(); tick(4);
    chk("R1 restart acks", {a0, a1, a2}, 3'b111);
    chk("R1 restart write", mem_model[9'h005], 8'h66);
    chk("R6 commit count", commit_cnt, c0 + 1);

    chk("R12 drive edges with SCL high", bad_edge, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule